// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers interrupt conditions from a timing module: a terminal-count event and a timestamp-capture event from each of eight channels, three serial-link error indications (carrier loss, framing, parity) and the timestamp sync event. Every condition sets a bit in one of three latched source groups: link, terminal count and timestamp. Enable bytes decide which latched bits take part in the request. A summary byte shows which groups have enabled bits pending. The block drives one interrupt request at a programmable 3-bit level, and it returns a programmable 8-bit vector during an acknowledge.

Reporting works on two levels. Software first reads the summary register, which withdraws the request. It then reads the source register of each flagged group, and that read clears only the group it reads. Each group also has a mirror address. A mirror read returns the same bits and clears nothing, so software can poll it safely. Any new enabled event raises the request again, even if the earlier one has not been serviced.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `irq_req` is low and `irq_vec` is 0x00.
- R2: The register map is:

  | Address | Register | Access |
  |---|---|---|
  | 0 | Per-channel terminal-count enables | read/write |
  | 1 | Miscellaneous enables (bits 7:3 only; bits 2:0 read 0) | read/write |
  | 2 | Interrupt level (bits 2:0 only) | read/write |
  | 3 | Vector | read/write |
  | 4 | Summary | read |
  | 5 / 6 | Link source / link mirror | read |
  | 7 / 8 | Terminal-count source / mirror | read |
  | 9 / 10 | Timestamp source / mirror | read |

  A written value reads back masked to the implemented bits. An enable or source bit set to 1 means enabled or pending.
- R3: A one-cycle condition pulse sets its source bit. Terminal-count and timestamp channel k use bit k. In the link byte, carrier is bit 3, frame is bit 4, parity is bit 5 and sync is bit 6. The bit stays set until its own source register is read. Mirror reads never clear it.
- R4: A source register read returns the bits held before the read and clears that group only.
- R5: A condition that arrives in the same cycle as the clearing read of its group stays latched.
- R6: Summary bit layout:
  - bit 3: any enabled carrier, frame or parity bit
  - bit 4: any enabled terminal-count bit
  - bit 6: the enabled sync bit
  - bit 7: any timestamp bit, when miscellaneous-enable bit 7 is set

  Other summary bits read 0.
- R7: A source bit that is disabled still latches and shows in its source and mirror registers. It sets no summary bit and no request.
- R8: `irq_req` rises in the cycle after an enabled condition pulse. A summary read drops it in the next cycle. The summary bits stay set.
- R9: A new enabled condition after a summary read raises `irq_req` again.
- R10: Once no enabled source bit is pending, `irq_req` is low.
- R11: `irq_level` equals the level register. `irq_vec` equals the vector register while `irq_iack` is high, and 0x00 otherwise.
- R12: One enable bit, miscellaneous bit 7, controls the timestamp captures of all eight channels together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; source and summary side effects act at the clock edge |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tc_evt | input | 8 | Per-channel terminal-count pulses |
| ts_evt | input | 8 | Per-channel timestamp-capture pulses |
| carrier_err | input | 1 | Link carrier error pulse |
| frame_err | input | 1 | Link frame error pulse |
| parity_err | input | 1 | Link parity error pulse |
| sync_evt | input | 1 | Timestamp sync event pulse |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed request level |
| irq_iack | input | 1 | Interrupt acknowledge |
| irq_vec | output | 8 | Vector returned during acknowledge |

## Verification
The assertions check on every cycle that:
- a latched source bit never drops unless its own group is read;
- a condition arriving during a clearing read survives;
- an enabled event raises the request in the next cycle;
- a summary read with no new event withdraws the request;
- the vector is zero outside an acknowledge.

The directed scenarios cover what the assertions cannot see:
- the bit positions in each register;
- the masking of disabled sources;
- the shared timestamp enable;
- the fact that mirror reads leave data untouched;
- the exact values returned by clearing reads.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int LVL_W  = 3;
  localparam int LINK_N = 4;

  typedef enum logic [AW-1:0] {
    A_EN_CH    = 4'd0,
    A_EN_MISC  = 4'd1,
    A_LEVEL    = 4'd2,
    A_VECTOR   = 4'd3,
    A_SUMMARY  = 4'd4,
    A_LINK_SRC = 4'd5,
    A_LINK_MIR = 4'd6,
    A_TC_SRC   = 4'd7,
    A_TC_MIR   = 4'd8,
    A_TS_SRC   = 4'd9,
    A_TS_MIR   = 4'd10
  } reg_addr_e;

  // bit positions shared by the link byte and the misc enable byte
  localparam int B_CARRIER = 3;
  localparam int B_FRAME   = 4;
  localparam int B_PARITY  = 5;
  localparam int B_SYNC    = 6;
  localparam int B_TSCAP   = 7;
  // summary-only positions
  localparam int S_LINKERR = 3;
  localparam int S_TC      = 4;

  localparam logic [DW-1:0] MISC_MASK = 8'hF8;
  localparam logic [DW-1:0] LERR_MASK = 8'h38;

  // packs the four link latch bits into their byte positions
  function automatic logic [DW-1:0] link_byte_f(input logic [LINK_N-1:0] q);
    logic [DW-1:0] b;
    b = '0;
    b[B_CARRIER] = q[0];
    b[B_FRAME]   = q[1];
    b[B_PARITY]  = q[2];
    b[B_SYNC]    = q[3];
    return b;
  endfunction

  // derives the summary byte from the latched groups and the enables
  function automatic logic [DW-1:0] summary_f(
    input logic [DW-1:0] link_b,
    input logic [DW-1:0] tc_b,
    input logic [DW-1:0] ts_b,
    input logic [DW-1:0] en_ch,
    input logic [DW-1:0] en_misc
  );
    logic [DW-1:0] s;
    s = '0;
    s[S_LINKERR] = |(link_b & en_misc & LERR_MASK);
    s[S_TC]      = |(tc_b & en_ch);
    s[B_SYNC]    = link_b[B_SYNC] & en_misc[B_SYNC];
    s[B_TSCAP]   = (|ts_b) & en_misc[B_TSCAP];
    return s;
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_rd_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (clr_rd_i) q_o[i] <= set_i[i];
      else               q_o[i] <= q_o[i] | set_i[i];
    end
  end

  // R3: without a clearing read no latched bit may drop
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd_i |=> ((q_o & $past(q_o)) == $past(q_o)));

  // R5: a condition coinciding with the clearing read survives it
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd_i && (set_i != '0)) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_grp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    en_ch_o,
  output logic [DW-1:0]    en_misc_o,
  output logic [LVL_W-1:0] level_o,
  output logic [DW-1:0]    vector_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ch_o   <= '0;
      en_misc_o <= '0;
      level_o   <= '0;
      vector_o  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_EN_CH:   en_ch_o   <= wdata_i;
        A_EN_MISC: en_misc_o <= wdata_i & MISC_MASK;
        A_LEVEL:   level_o   <= wdata_i[LVL_W-1:0];
        A_VECTOR:  vector_o  <= wdata_i;
        default:   ;
      endcase
    end
  end

  // R11: a level write takes effect on the next cycle
  p_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_LEVEL) |=> (level_o == $past(wdata_i[LVL_W-1:0])));
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic new_evt_i,
  input  logic sum_rd_i,
  output logic irq_o
);
  logic acked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acked_q <= 1'b0;
    else if (new_evt_i || !pend_i) acked_q <= 1'b0;
    else if (sum_rd_i)            acked_q <= 1'b1;
  end

  assign irq_o = pend_i & ~acked_q;

  // R9: an enabled new event raises the request next cycle
  p_reassert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    new_evt_i |=> irq_o);

  // R8: a summary read without a new event withdraws the request
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_rd_i && !new_evt_i) |=> !irq_o);
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_rd,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NCH-1:0]   tc_evt,
  input  logic [NCH-1:0]   ts_evt,
  input  logic             carrier_err,
  input  logic             frame_err,
  input  logic             parity_err,
  input  logic             sync_evt,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level,
  input  logic             irq_iack,
  output logic [DW-1:0]    irq_vec
);
  localparam int PAD = DW - NCH;

  logic [DW-1:0]     en_ch, en_misc, vector_q;
  logic [LINK_N-1:0] link_set, link_q;
  logic [NCH-1:0]    tc_q, ts_q;
  logic [DW-1:0]     link_b, tc_b, ts_b, summary;
  logic              clr_link, clr_tc, clr_ts, sum_rd;
  logic              new_evt, pending;

  irq_cfg_regs u_cfg (
    .clk, .rst_n,
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .en_ch_o(en_ch), .en_misc_o(en_misc),
    .level_o(irq_level), .vector_o(vector_q)
  );

  assign clr_link = reg_rd && (reg_addr == A_LINK_SRC);
  assign clr_tc   = reg_rd && (reg_addr == A_TC_SRC);
  assign clr_ts   = reg_rd && (reg_addr == A_TS_SRC);
  assign sum_rd   = reg_rd && (reg_addr == A_SUMMARY);
  assign link_set = {sync_evt, parity_err, frame_err, carrier_err};

  irq_src_latch #(.W(LINK_N)) u_link (
    .clk, .rst_n, .set_i(link_set), .clr_rd_i(clr_link), .q_o(link_q));
  irq_src_latch #(.W(NCH)) u_tc (
    .clk, .rst_n, .set_i(tc_evt), .clr_rd_i(clr_tc), .q_o(tc_q));
  irq_src_latch #(.W(NCH)) u_ts (
    .clk, .rst_n, .set_i(ts_evt), .clr_rd_i(clr_ts), .q_o(ts_q));

  assign link_b  = link_byte_f(link_q);
  assign tc_b    = {{PAD{1'b0}}, tc_q};
  assign ts_b    = {{PAD{1'b0}}, ts_q};
  assign summary = summary_f(link_b, tc_b, ts_b, en_ch, en_misc);
  assign pending = |summary;

  // incoming events that would raise an enabled summary bit
  assign new_evt = (|summary_f(link_byte_f(link_set), {{PAD{1'b0}}, tc_evt},
                               {{PAD{1'b0}}, ts_evt}, en_ch, en_misc));

  irq_req_ctrl u_req (
    .clk, .rst_n, .pend_i(pending), .new_evt_i(new_evt),
    .sum_rd_i(sum_rd), .irq_o(irq_req));

  assign irq_vec = irq_iack ? vector_q : '0;

  always_comb begin
    case (reg_addr)
      A_EN_CH:                reg_rdata = en_ch;
      A_EN_MISC:              reg_rdata = en_misc;
      A_LEVEL:                reg_rdata = {{(DW-LVL_W){1'b0}}, irq_level};
      A_VECTOR:               reg_rdata = vector_q;
      A_SUMMARY:              reg_rdata = summary;
      A_LINK_SRC, A_LINK_MIR: reg_rdata = link_b;
      A_TC_SRC, A_TC_MIR:     reg_rdata = tc_b;
      A_TS_SRC, A_TS_MIR:     reg_rdata = ts_b;
      default:                reg_rdata = '0;
    endcase
  end

  // R10: a request is only ever raised over a non-empty summary
  p_req_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (summary != '0));

  // R11: no vector is driven outside an acknowledge
  p_vec_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_iack |-> (irq_vec == '0));
endmodule

// File: tb/irq_group_ctrl_bench.sv
module irq_group_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] tc_evt = '0, ts_evt = '0;
  logic       carrier_err = 0, frame_err = 0, parity_err = 0, sync_evt = 0;
  logic       irq_req, irq_iack = 1'b0;
  logic [2:0] irq_level;
  logic [7:0] irq_vec;
  int total = 0, bad = 0;
  bit done = 0;

  irq_group_ctrl u_irq_group_ctrl (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 4'(a); reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; #1;
  endtask

  task automatic pulse(input int tc, input int ts, input int link);
    @(negedge clk);
    tc_evt = 8'(tc); ts_evt = 8'(ts);
    {sync_evt, parity_err, frame_err, carrier_err} = 4'(link);
    @(negedge clk);
    tc_evt = 0; ts_evt = 0; {sync_evt, parity_err, frame_err, carrier_err} = 0;
    #1;
  endtask

  task automatic t_reset();
    int d;
    for (int a = 0; a <= 10; a++) begin
      rd(a, d);
      check($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    check("R1 irq_req after reset", irq_req, 0);
    check("R1 irq_vec after reset", irq_vec, 0);
  endtask

  task automatic t_regs();
    int d;
    wr(0, 8'hA5); rd(0, d); check("R2 en_ch readback", d, 8'hA5);
    wr(1, 8'hFF); rd(1, d); check("R2 en_misc masked", d, 8'hF8);
    wr(2, 8'hFD); rd(2, d); check("R2 level masked", d, 5);
    check("R11 irq_level port", irq_level, 5);
    wr(3, 8'h6C); rd(3, d); check("R2 vector readback", d, 8'h6C);
    check("R11 vec without iack", irq_vec, 0);
    @(negedge clk); irq_iack = 1; #1 check("R11 vec during iack", irq_vec, 8'h6C);
    @(negedge clk); irq_iack = 0;
    wr(0, 0); wr(1, 0);
  endtask

  task automatic t_latch_mirror();
    int d;
    pulse(8'h81, 0, 0);
    rd(8, d); check("R3 tc mirror", d, 8'h81);
    rd(8, d); check("R3 mirror read keeps bits", d, 8'h81);
    rd(7, d); check("R4 tc source read value", d, 8'h81);
    rd(8, d); check("R4 tc cleared after read", d, 0);
    pulse(0, 8'h12, 4'b0101);
    rd(6, d); check("R3 link bits carrier+parity", d, 8'h28);
    rd(5, d); check("R4 link source read", d, 8'h28);
    rd(10, d); check("R4 ts untouched by link read", d, 8'h12);
    rd(9, d); rd(10, d); check("R4 ts cleared", d, 0);
  endtask

  task automatic t_same_cycle();
    int d;
    pulse(8'h01, 0, 0);
    @(negedge clk); reg_addr = 4'd7; reg_rd = 1; tc_evt = 8'h02; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; tc_evt = 0; #1;
    check("R5 read returns earlier bit", d, 8'h01);
    rd(8, d); check("R5 coincident bit kept", d, 8'h02);
    rd(7, d);
  endtask

  task automatic t_summary_disabled();
    int d;
    wr(0, 8'h01); wr(1, 8'h78);
    pulse(8'h04, 8'h08, 0);
    check("R7 disabled tc no request", irq_req, 0);
    rd(4, d); check("R7 summary empty", d, 0);
    rd(8, d); check("R7 disabled tc still latched", d, 8'h04);
    rd(7, d); rd(9, d);
    pulse(0, 0, 4'b1010);
    rd(4, d); check("R6 summary link+sync", d, 8'h48);
    rd(5, d); check("R6 link source frame+sync", d, 8'h50);
    wr(1, 0);
  endtask

  task automatic t_request();
    int d;
    wr(0, 8'hFF);
    pulse(8'h01, 0, 0);
    check("R8 request after event", irq_req, 1);
    rd(4, d); check("R6 summary tc bit", d, 8'h10);
    check("R8 request dropped by summary read", irq_req, 0);
    rd(4, d); check("R8 summary bits persist", d, 8'h10);
    check("R8 still dropped", irq_req, 0);
    pulse(8'h08, 0, 0);
    check("R9 request re-raised", irq_req, 1);
    rd(7, d); check("R4 tc source both bits", d, 8'h09);
    check("R10 request low when nothing pending", irq_req, 0);
    wr(0, 0);
  endtask

  task automatic t_ts_shared();
    int d;
    pulse(0, 8'h24, 0);
    check("R12 ts disabled no request", irq_req, 0);
    wr(1, 8'h80);
    check("R12 shared enable raises request", irq_req, 1);
    rd(4, d); check("R12 summary ts bit", d, 8'h80);
    rd(9, d); check("R12 ts source all channels", d, 8'h24);
    check("R10 request low after ts cleared", irq_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_latch_mirror();
    t_same_cycle();
    t_summary_disabled();
    t_request();
    t_ts_shared();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule